// File: doc/BRIEF.md
# DRAM Refresh Controller with CAS-before-RAS Sequencer

This block holds a 32-bit control word for DRAM refresh and runs the refresh engine that uses it. Software programs a 12-bit refresh interval and a 4-bit row-strobe width through a simple register port, with a write strobe and read data. The interval applies to asynchronous and synchronous DRAM alike. An interval counter advances on every memory-clock tick, marked by `mclk_en`. When the programmed number of ticks has elapsed, the counter raises a refresh request and reloads.

The request goes to the access arbiter on a request/grant pair. The request stays high until it is granted, and a grant has no effect while there is no request. Once granted, the sequencer runs one CAS-before-RAS cycle. The column strobe and DQM rise one tick ahead of the row strobe. All three are then held together while the row strobe lasts, for the programmed width plus one ticks. If a further interval elapses while a request is still waiting, a sticky overrun flag is raised.

The interval field and the width field both come out of reset at zero. An interval of zero keeps the engine quiet. Systems with SDRAM must program a width of at least 1.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset `reg_rdata` reads 0x8000_0000, `ref_req`, `row_strb`, `col_strb`, `dqm` and `overrun` are all 0.
- R2: Bits [3:0] hold the row-strobe width, bits [15:4] the refresh interval and bit 31 the self-refresh status. All three are writable, and `reg_rdata` returns the written value from the clock edge after the write.
- R3: Bits [30:16] are reserved: writes to them are ignored and they read 0.
- R4: With a non-zero interval N, `ref_req` rises on the N-th `mclk_en` tick after the last register write. The counter then reloads and counts the next N ticks, whether or not the refresh has been served.
- R5: While the interval field is 0, `ref_req` never rises.
- R6: `ref_req` stays high until a tick on which `ref_gnt` is high. The refresh cycle starts on that tick and `ref_req` drops.
- R7: On the start tick, `col_strb` and `dqm` rise alone. From the next tick, `row_strb` is also high, for width+1 ticks, with the width captured at start. All three then fall together.
- R8: An interval elapsing while a request is still ungranted sets `overrun`, which stays set until reset.
- R9: Any register write clears a pending request and restarts the interval count from zero.
- R10: Register writes take effect on the clock edge whether or not `mclk_en` is high. All refresh timing advances only on ticks where `mclk_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mclk_en | input | 1 | Memory-clock tick enable |
| ref_req | output | 1 | Refresh request to access arbiter |
| ref_gnt | input | 1 | Grant from access arbiter |
| row_strb | output | 1 | Row strobe / chip select, active high |
| col_strb | output | 1 | Column strobe, active high |
| dqm | output | 1 | Data mask, active high |
| overrun | output | 1 | Sticky missed-refresh flag |

## Verification
Every output is registered and has no combinational path from any input. Register read data is valid from the first clock edge after a write. `ref_req` appears one edge after the counter reaches its limit. The strobes change on the same edge as the tick that moves the sequencer. The bench drives its inputs just after the falling edge and reads the outputs one time unit after the next rising edge, or at the falling edge. Its cycle model is advanced on that same rising edge, so each comparison falls in the cycle where the result is due.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAS  = 2'd1,
    ST_RAS  = 2'd2
  } cbr_state_e;
endpackage

// File: rtl/dref_regs.sv
module dref_regs #(
  parameter int DATA_W = 32,
  parameter int RASW_W = 4,
  parameter int IVAL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [RASW_W-1:0] rasw,
  output logic [IVAL_W-1:0] ival,
  output logic [DATA_W-1:0] rdata
);
  localparam int IVAL_LSB = RASW_W;
  localparam int SELF_BIT = DATA_W - 1;

  logic self_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rasw    <= '0;
      ival    <= '0;
      self_st <= 1'b1;
    end else if (we) begin
      rasw    <= wdata[RASW_W-1:0];
      ival    <= wdata[IVAL_LSB +: IVAL_W];
      self_st <= wdata[SELF_BIT];
    end
  end

  always_comb begin
    rdata                       = '0;
    rdata[RASW_W-1:0]           = rasw;
    rdata[IVAL_LSB +: IVAL_W]   = ival;
    rdata[SELF_BIT]             = self_st;
  end

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[IVAL_LSB+IVAL_W-1:0] == $past(wdata[IVAL_LSB+IVAL_W-1:0])));
endmodule

// File: rtl/dref_timer.sv
module dref_timer #(
  parameter int IVAL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  logic [IVAL_W-1:0] ival,
  input  logic              start,
  output logic              pending,
  output logic              overrun
);
  logic [IVAL_W-1:0] cnt;
  logic              at_lim;
  logic              elapse;

  assign at_lim = (ival != '0) && (cnt >= ival - IVAL_W'(1));
  assign elapse = tick && !wr && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr) begin
      cnt <= '0;
    end else if (tick && ival != '0) begin
      cnt <= at_lim ? '0 : cnt + IVAL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (wr) begin
        pending <= 1'b0;
      end else if (elapse) begin
        pending <= 1'b1;
      end else if (start) begin
        pending <= 1'b0;
      end
      if (elapse && pending && !start) begin
        overrun <= 1'b1;
      end
    end
  end

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_no_req_zero_ival_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> (ival != '0));
  assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !pending);
endmodule

// File: rtl/dref_seq.sv
module dref_seq
  import dref_pkg::*;
#(
  parameter int RASW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pending,
  input  logic              gnt,
  input  logic [RASW_W-1:0] rasw,
  output logic              req,
  output logic              start,
  output logic              row,
  output logic              col,
  output logic              dqm
);
  cbr_state_e        state;
  logic [RASW_W-1:0] wcnt;
  logic [RASW_W-1:0] ras_lat;

  assign req   = pending && (state == ST_IDLE);
  assign start = tick && req && gnt;
  assign col   = (state != ST_IDLE);
  assign dqm   = (state != ST_IDLE);
  assign row   = (state == ST_RAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wcnt    <= '0;
      ras_lat <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_CAS;
          ras_lat <= rasw;
        end
        ST_CAS: if (tick) begin
          state <= ST_RAS;
          wcnt  <= '0;
        end
        ST_RAS: if (tick) begin
          if (wcnt == ras_lat) state <= ST_IDLE;
          else                 wcnt  <= wcnt + RASW_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_col_leads_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row) |-> $past(col) && !$past(row));
  assert_row_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RAS) |-> (wcnt <= ras_lat));
  assert_start_on_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col) |-> $past(req && gnt && tick));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int DATA_W = 32,
  parameter int RASW_W = 4,
  parameter int IVAL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mclk_en,
  output logic              ref_req,
  input  logic              ref_gnt,
  output logic              row_strb,
  output logic              col_strb,
  output logic              dqm,
  output logic              overrun
);
  logic [RASW_W-1:0] rasw;
  logic [IVAL_W-1:0] ival;
  logic              pending;
  logic              start;

  dref_regs #(.DATA_W(DATA_W), .RASW_W(RASW_W), .IVAL_W(IVAL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .rasw(rasw), .ival(ival), .rdata(reg_rdata)
  );

  dref_timer #(.IVAL_W(IVAL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(mclk_en), .wr(reg_we), .ival(ival),
    .start(start), .pending(pending), .overrun(overrun)
  );

  dref_seq #(.RASW_W(RASW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(mclk_en), .pending(pending),
    .gnt(ref_gnt), .rasw(rasw), .req(ref_req), .start(start),
    .row(row_strb), .col(col_strb), .dqm(dqm)
  );

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we) |-> (reg_rdata[DATA_W-2:RASW_W+IVAL_W] == '0));
  assert_strobes_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !col_strb |-> (!row_strb && !dqm));
endmodule

// File: tb/tb_dram_refresh_ctrl.sv
module tb_dram_refresh_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mclk_en = 1'b0;
  logic        ref_req;
  logic        ref_gnt = 1'b0;
  logic        row_strb, col_strb, dqm, overrun;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  dram_refresh_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mclk_en(mclk_en), .ref_req(ref_req),
    .ref_gnt(ref_gnt), .row_strb(row_strb), .col_strb(col_strb),
    .dqm(dqm), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from R2, R4, R6..R10
  logic [3:0]  m_ras, m_lat, m_w;
  logic [11:0] m_ival, m_cnt;
  logic        m_self, m_pend, m_ovr;
  int          m_st;

  function automatic logic [31:0] exp_rdata();
    return {m_self, 15'd0, m_ival, m_ras};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ras = 0; m_ival = 0; m_self = 1; m_cnt = 0; m_pend = 0;
      m_ovr = 0; m_st = 0; m_w = 0; m_lat = 0;
    end else begin
      logic st, el, lim;
      st  = mclk_en && m_st == 0 && m_pend && ref_gnt;
      lim = m_ival != 0 && m_cnt >= m_ival - 12'd1;
      el  = mclk_en && !reg_we && lim;
      if (m_st == 0) begin
        if (st) begin m_st = 1; m_lat = m_ras; end
      end else if (m_st == 1) begin
        if (mclk_en) begin m_st = 2; m_w = 0; end
      end else if (mclk_en) begin
        if (m_w == m_lat) m_st = 0; else m_w = m_w + 4'd1;
      end
      if (el && m_pend && !st) m_ovr = 1;
      if (reg_we) m_pend = 0;
      else if (el) m_pend = 1;
      else if (st) m_pend = 0;
      if (reg_we) m_cnt = 0;
      else if (mclk_en && m_ival != 0) m_cnt = lim ? 12'd0 : m_cnt + 12'd1;
      if (reg_we) begin
        m_ras = reg_wdata[3:0]; m_ival = reg_wdata[15:4]; m_self = reg_wdata[31];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk("R6 ref_req", {31'd0, ref_req}, {31'd0, m_pend && m_st == 0});
      chk("R7 col_strb", {31'd0, col_strb}, {31'd0, m_st != 0});
      chk("R7 dqm", {31'd0, dqm}, {31'd0, m_st != 0});
      chk("R7 row_strb", {31'd0, row_strb}, {31'd0, m_st == 2});
      chk("R8 overrun", {31'd0, overrun}, {31'd0, m_ovr});
      chk("R2 reg_rdata", reg_rdata, exp_rdata());
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic cyc(bit en, bit g, bit we, logic [31:0] wd);
    @(negedge clk);
    mclk_en = en; ref_gnt = g; reg_we = we; reg_wdata = wd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rdata", reg_rdata, 32'h8000_0000);
    chk("R1 strobes", {28'd0, ref_req, row_strb, col_strb, dqm}, 32'd0);
    chk("R1 overrun", {31'd0, overrun}, 32'd0);
    model_on = 1'b1;

    // R3 reserved bits ignored
    cyc(1, 0, 1, 32'hFFFF_FFFF);
    chk("R3 reserved", reg_rdata, 32'h8000_FFFF);
    // R10 write lands with tick low
    cyc(0, 0, 1, 32'h0000_0123);
    chk("R10 write no tick", reg_rdata, 32'h0000_0123);
    // R5 zero interval stays quiet
    cyc(1, 1, 1, 32'h0000_0001);
    for (int i = 0; i < 200; i++) begin
      cyc(1, 1, 0, 0);
      if (i % 50 == 0) chk("R5 no request", {31'd0, ref_req}, 32'd0);
    end
    // R4 interval 5, width 1
    cyc(1, 0, 1, 32'h0000_0051);
    for (int i = 1; i <= 4; i++) begin
      cyc(1, 0, 0, 0);
      chk("R4 early", {31'd0, ref_req}, 32'd0);
    end
    cyc(1, 0, 0, 0);
    chk("R4 due", {31'd0, ref_req}, 32'd1);
    // R6 held until grant
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 0, 0);
      chk("R6 held", {31'd0, ref_req}, 32'd1);
    end
    cyc(1, 1, 0, 0);
    chk("R7 cas first", {29'd0, row_strb, col_strb, dqm}, 32'b011);
    chk("R6 req drops", {31'd0, ref_req}, 32'd0);
    cyc(1, 0, 0, 0);
    chk("R7 ras on", {29'd0, row_strb, col_strb, dqm}, 32'b111);
    cyc(1, 0, 0, 0);
    chk("R7 ras hold", {29'd0, row_strb, col_strb, dqm}, 32'b111);
    cyc(1, 0, 0, 0);
    chk("R7 ras end", {29'd0, row_strb, col_strb, dqm}, 32'b000);
    chk("R4 reload", {31'd0, ref_req}, 32'd1);
    // R8 overrun after ungranted interval
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0);
    chk("R8 overrun set", {31'd0, overrun}, 32'd1);
    // R9 write clears request
    cyc(1, 0, 1, 32'h8000_0070);
    chk("R9 cleared", {31'd0, ref_req}, 32'd0);
    chk("R8 sticky", {31'd0, overrun}, 32'd1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      bit en, g, we;
      logic [31:0] wd;
      en = ($urandom % 4) != 0;
      g  = ($urandom % 3) == 0;
      we = ($urandom % 150) == 0;
      wd = $urandom;
      wd[15:4] = 12'($urandom % 24);
      cyc(en, g, we, wd);
    end
    // Width extremes with steady grant
    cyc(1, 1, 1, 32'h0000_003F);
    for (int i = 0; i < 200; i++) cyc(1, 1, 0, 0);
    cyc(1, 1, 1, 32'h0000_0020);
    for (int i = 0; i < 200; i++) cyc(1, 1, 0, 0);
    @(negedge clk);
    summary();
  end
endmodule